// File: doc/BRIEF.md
# Character-Time Pacing and FIFO Timeout Timers

This block supplies all of the timing for a UART emulation that moves bytes in parallel and has no real serial line. A cascade of three 8-bit reloadable down-counters, advanced by a divided baud-clock enable, paces the emulated transfer rate. Together the three stages span a 24-bit count. Two more 8-bit timers stand in for the four-character-time FIFO timeout, one per direction. Each raises a sticky expiry flag for the local processor when its FIFO has sat non-empty with no character moved for the programmed number of enables.

Every timer has its own reload register, loaded through a shared write-data bus and a per-timer write strobe. A write also loads the live count. A reload value of zero parks the timer. The pacing chain has a restart strobe that rewinds every stage to its reload value. Each pacing stage reports its terminal count as a registered one-cycle pulse. The top stage's pulse is the character pacing event.

Top module: `char_time_timers`

## Requirements
- R1: After reset every reload register and count is zero, `pace_tick_o` is 3'b000 and `to_expired_o` is 2'b00; enables then produce no tick and no expiry.
- R2: Pacing stage 0 with reload R pulses its tick once every R cycles in which `baud_en_i` is high; cycles with `baud_en_i` low leave its count unchanged.
- R3: Pacing stage k+1 decrements only in a cycle in which stage k reaches terminal count. Bit k of `pace_tick_o` is stage k. The top stage therefore ticks once every R0*R1*R2 enables.
- R4: A tick appears on `pace_tick_o` in the cycle after the clock edge at which the terminal enable was taken, and it lasts exactly one cycle.
- R5: A pacing stage whose reload is zero never ticks, so the stages above it never advance.
- R6: `pace_restart_i` reloads every pacing count from its reload value and leaves the reload values unchanged.
- R7: A write to a timer's reload register loads its count at the same time, so the next period starts from the written value.
- R8: A timeout timer with reload R sets its expiry flag after R enables taken while its FIFO is non-empty. While the FIFO is empty, the timer is held at its reload value.
- R9: A character transfer strobe on `to_kick_i` restarts that direction's timeout count from its reload value.
- R10: An expiry flag stays set until `to_clr_i` for that direction is asserted. If a new expiry arrives in the same cycle as the clear, the flag stays set.
- R11: A timeout timer whose reload is zero never expires.
- R12: The receive timeout (index 0) and the transmit timeout (index 1) run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_en_i | input | 1 | Divided baud-clock enable; each high cycle is one count step |
| wdata_i | input | 8 | Reload value shared by all write strobes |
| pace_wr_i | input | 3 | Per-stage reload write strobe for the pacing chain |
| pace_restart_i | input | 1 | Rewinds all pacing counts to their reload values |
| pace_tick_o | output | 3 | Registered terminal-count pulse for each pacing stage |
| to_wr_i | input | 2 | Reload write strobe per timeout timer (0 receive, 1 transmit) |
| to_kick_i | input | 2 | Character transferred in that direction |
| to_nonempty_i | input | 2 | FIFO of that direction holds data |
| to_clr_i | input | 2 | Clears the expiry flag of that direction |
| to_expired_o | output | 2 | Sticky timeout expiry flag per direction |

## Verification
A wrong count in a pacing stage shows as a tick on the wrong enable. The error is visible on that stage's bit of `pace_tick_o` within one period of the stage. It reaches the top bit only after the full product period, so per-stage tick totals over long enable runs are compared against floor divisions of the enable count. A corrupted timeout count or a missed restart moves the rising edge of `to_expired_o` by whole enables. Because the flag is sticky, a false expiry stays visible until the bench clears it. The bench therefore samples the flag just before and just after the expected expiring enable.

// File: rtl/ctime_pkg.sv
package ctime_pkg;
  localparam int unsigned CT_STAGE_W     = 8;
  localparam int unsigned CT_PACE_STAGES = 3;
  localparam int unsigned CT_DIRS        = 2;
endpackage

// File: rtl/ctime_pace_stage.sv
module ctime_pace_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         restart_i,
  output logic         tick_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] reload_q, cnt_q;
  logic         armed;

  assign armed  = (reload_q != '0);
  assign tick_o = en_i && armed && (cnt_q == ONE) && !wr_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (wr_i) begin
      reload_q <= wdata_i;
      cnt_q    <= wdata_i;
    end else if (restart_i || tick_o) begin
      cnt_q <= reload_q;
    end else if (en_i && armed) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assert_cnt_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (cnt_q != '0 && cnt_q <= reload_q));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ctime_fifo_timeout.sv
module ctime_fifo_timeout #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         kick_i,
  input  logic         nonempty_i,
  input  logic         clr_i,
  output logic         expired_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] reload_q, cnt_q;
  logic         armed, rewind, hit;

  assign armed  = (reload_q != '0);
  assign rewind = kick_i || !nonempty_i;
  assign hit    = en_i && armed && !rewind && !wr_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (wr_i) begin
      reload_q <= wdata_i;
      cnt_q    <= wdata_i;
    end else if (rewind || hit) begin
      cnt_q <= reload_q;
    end else if (en_i && armed) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // set wins over clear so a fresh expiry is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     expired_o <= 1'b0;
    else if (hit)    expired_o <= 1'b1;
    else if (clr_i)  expired_o <= 1'b0;
  end

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);

  assert_rise_nonempty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_o) |-> $past(nonempty_i));

  assert_zero_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/char_time_timers.sv
module char_time_timers
  import ctime_pkg::*;
#(
  parameter int unsigned STAGE_W     = CT_STAGE_W,
  parameter int unsigned PACE_STAGES = CT_PACE_STAGES,
  parameter int unsigned DIRS        = CT_DIRS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   baud_en_i,
  input  logic [STAGE_W-1:0]     wdata_i,
  input  logic [PACE_STAGES-1:0] pace_wr_i,
  input  logic                   pace_restart_i,
  output logic [PACE_STAGES-1:0] pace_tick_o,
  input  logic [DIRS-1:0]        to_wr_i,
  input  logic [DIRS-1:0]        to_kick_i,
  input  logic [DIRS-1:0]        to_nonempty_i,
  input  logic [DIRS-1:0]        to_clr_i,
  output logic [DIRS-1:0]        to_expired_o
);
  logic [PACE_STAGES:0]   chain_en;
  logic [PACE_STAGES-1:0] stage_tick;

  assign chain_en[0] = baud_en_i;

  for (genvar k = 0; k < PACE_STAGES; k++) begin : g_pace
    ctime_pace_stage #(.W(STAGE_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (chain_en[k]),
      .wr_i      (pace_wr_i[k]),
      .wdata_i   (wdata_i),
      .restart_i (pace_restart_i),
      .tick_o    (stage_tick[k])
    );
    assign chain_en[k+1] = stage_tick[k];

    if (k > 0) begin : g_chk
      assert_cascade_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pace_tick_o[k] |-> pace_tick_o[k-1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pace_tick_o <= '0;
    else         pace_tick_o <= stage_tick;
  end

  for (genvar d = 0; d < DIRS; d++) begin : g_to
    ctime_fifo_timeout #(.W(STAGE_W)) u_to (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (baud_en_i),
      .wr_i       (to_wr_i[d]),
      .wdata_i    (wdata_i),
      .kick_i     (to_kick_i[d]),
      .nonempty_i (to_nonempty_i[d]),
      .clr_i      (to_clr_i[d]),
      .expired_o  (to_expired_o[d])
    );
  end

  assert_tick_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pace_tick_o[0] |-> $past(baud_en_i));
endmodule

// File: tb/char_time_timers_tb.sv
module char_time_timers_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [2:0] pace_wr_i = '0;
  logic       pace_restart_i = 1'b0;
  logic [2:0] pace_tick_o;
  logic [1:0] to_wr_i = '0, to_kick_i = '0, to_nonempty_i = '0, to_clr_i = '0;
  logic [1:0] to_expired_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  char_time_timers dut_i (.*);

  localparam int NV = 8;
  localparam int V_R0[NV] = '{3, 1, 5, 0, 255, 2, 7, 1};
  localparam int V_R1[NV] = '{2, 1, 0, 4,   2, 3, 1, 255};
  localparam int V_R2[NV] = '{2, 1, 7, 4,   1, 4, 3, 1};
  localparam int V_N [NV] = '{40, 5, 30, 20, 520, 60, 50, 260};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cnt0, cnt1, cnt2;

  task automatic pulse();
    @(negedge clk_i) baud_en_i = 1'b1;
    @(negedge clk_i) baud_en_i = 1'b0;
    cnt0 += int'(pace_tick_o[0]);
    cnt1 += int'(pace_tick_o[1]);
    cnt2 += int'(pace_tick_o[2]);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic wr_pace(int idx, int val);
    @(negedge clk_i) wdata_i = 8'(val); pace_wr_i = 3'(1 << idx);
    @(negedge clk_i) pace_wr_i = '0;
  endtask

  task automatic wr_to(int idx, int val);
    @(negedge clk_i) wdata_i = 8'(val); to_wr_i = 2'(1 << idx);
    @(negedge clk_i) to_wr_i = '0;
  endtask

  task automatic restart();
    @(negedge clk_i) pace_restart_i = 1'b1;
    @(negedge clk_i) pace_restart_i = 1'b0;
  endtask

  task automatic clr(int idx);
    @(negedge clk_i) to_clr_i = 2'(1 << idx);
    @(negedge clk_i) to_clr_i = '0;
  endtask

  task automatic zero_cnt();
    cnt0 = 0; cnt1 = 0; cnt2 = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    zero_cnt();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 tick after reset", int'(pace_tick_o), 0);
    check("R1 expired after reset", int'(to_expired_o), 0);
    to_nonempty_i = 2'b11;
    pulses(10);
    check("R1 R5 no tick with zero reloads", cnt0 + cnt1 + cnt2, 0);
    check("R1 no expiry with zero reloads", int'(to_expired_o), 0);
    to_nonempty_i = 2'b00;

    // vector table: per-stage tick totals = cascaded floor division (R2 R3 R5)
    for (int v = 0; v < NV; v++) begin
      int e0, e1, e2;
      wr_pace(0, V_R0[v]); wr_pace(1, V_R1[v]); wr_pace(2, V_R2[v]);
      zero_cnt();
      pulses(V_N[v]);
      e0 = (V_R0[v] == 0) ? 0 : V_N[v] / V_R0[v];
      e1 = (V_R1[v] == 0) ? 0 : e0 / V_R1[v];
      e2 = (V_R2[v] == 0) ? 0 : e1 / V_R2[v];
      check("R2 stage0 ticks", cnt0, e0);
      check("R3 stage1 ticks", cnt1, e1);
      check("R3 R5 stage2 ticks", cnt2, e2);
    end

    // R4: single-cycle pulse, visible right after the enable edge
    wr_pace(0, 1); wr_pace(1, 1); wr_pace(2, 1);
    @(negedge clk_i) baud_en_i = 1'b1;
    @(negedge clk_i) baud_en_i = 1'b0;
    check("R4 tick after enable edge", int'(pace_tick_o), 7);
    @(negedge clk_i);
    check("R4 tick lasts one cycle", int'(pace_tick_o), 0);

    // R2: enable low holds count
    wr_pace(0, 2);
    zero_cnt();
    pulse();
    repeat (20) @(negedge clk_i);
    check("R2 no tick while enable low", cnt0, 0);
    pulse();
    check("R2 count held across idle", cnt0, 1);

    // R6: restart rewinds counts
    wr_pace(0, 4);
    zero_cnt();
    pulses(2);
    restart();
    pulses(3);
    check("R6 no tick before rewound period", cnt0, 0);
    pulse();
    check("R6 tick at full period after restart", cnt0, 1);

    // R7: write loads count immediately
    zero_cnt();
    pulse();
    wr_pace(0, 3);
    pulses(2);
    check("R7 no tick before written period", cnt0, 0);
    pulse();
    check("R7 tick at written period", cnt0, 1);

    // timeouts: dir1 parked with zero reload throughout (R11)
    to_nonempty_i = 2'b11;
    wr_to(0, 4);
    pulses(3);
    check("R8 not expired before period", int'(to_expired_o), 0);
    pulse();
    check("R8 expired at period", int'(to_expired_o), 1);
    repeat (5) @(negedge clk_i);
    check("R10 flag sticky", int'(to_expired_o), 1);
    clr(0);
    check("R10 flag cleared", int'(to_expired_o), 0);

    pulses(3);
    @(negedge clk_i) to_kick_i = 2'b01;
    @(negedge clk_i) to_kick_i = 2'b00;
    pulses(3);
    check("R9 kick restarted count", int'(to_expired_o), 0);
    pulse();
    check("R9 expiry after kick period", int'(to_expired_o), 1);

    pulses(3);
    @(negedge clk_i) baud_en_i = 1'b1; to_clr_i = 2'b01;
    @(negedge clk_i) baud_en_i = 1'b0; to_clr_i = 2'b00;
    check("R10 set wins over clear", int'(to_expired_o), 1);
    clr(0);
    check("R10 clear alone", int'(to_expired_o), 0);

    to_nonempty_i = 2'b10;
    pulses(10);
    check("R8 no expiry while empty", int'(to_expired_o), 0);
    to_nonempty_i = 2'b11;
    pulses(3);
    check("R8 count held at reload while empty", int'(to_expired_o), 0);
    pulse();
    check("R8 expiry after refill period", int'(to_expired_o[0]), 1);
    check("R11 zero reload never expires", int'(to_expired_o[1]), 0);
    clr(0);

    to_nonempty_i = 2'b10;
    wr_to(1, 6);
    pulses(5);
    check("R12 tx not yet expired", int'(to_expired_o), 0);
    pulse();
    check("R12 only tx expired", int'(to_expired_o), 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule